// File: doc/BRIEF.md
# Bus Clock Ratio Enable Generator

This block turns one source tick stream into three aligned clock-enable pulses for a bus hierarchy: a top-level enable, a mid-level enable and a low-level enable. The top enable fires once every N selected source ticks, where N is programmable. The two lower enables fire on a programmable subset of top-enable cycles, so each of their pulses always coincides with a top-enable pulse. The block runs on one clock. The two source inputs are per-cycle tick qualifiers, not clocks, and the outputs are enables for downstream logic.

Software programs a single 16-bit setting through a masked write port. The upper 16 bits of the write word are a per-bit write mask. A write whose merged result is an illegal ratio code is refused and raises an error flag. An accepted setting is staged and is loaded into the running dividers only at the cycle where all three dividers wrap together. A ratio change therefore never produces a shortened period. The configuration port has no handshake: a write takes effect at the clock edge where `cfg_we` is high.

Field layout of the setting (bit positions): [4:0] top divisor minus one; [7:5] pre-divider minus one (plain mode only); [9:8] mid ratio code; [12:10] low ratio code; [13] ratio mode (0 = power-of-two, 1 = plain); [14] source select (0 = `src0_tick`, 1 = `src1_tick`); [15] spare, stored with no effect.

Top module: `bus_ratio_gen`

## Requirements
- R1: In power-of-two mode, `aclk_en` pulses once every (field[4:0]+1) ticks of the selected source, and the pre-divider field has no effect.
- R2: In plain mode, the top divisor is (field[4:0]+1)·(field[7:5]+1) selected ticks.
- R3: In power-of-two mode, `hclk_en` fires on every 2^code-th top pulse for mid code 0..2, and `pclk_en` fires on every 2^code-th top pulse for low code 0..3.
- R4: In plain mode, `hclk_en` fires on every (code+1)-th top pulse for mid codes 0, 1 and 3, and `pclk_en` fires on every (code+1)-th top pulse for low codes 0..7.
- R5: `hclk_en` and `pclk_en` are high only in cycles where `aclk_en` is high. All three are registered and are one cycle wide.
- R6: With bit 14 = 0 only `src0_tick` advances the dividers. With bit 14 = 1 only `src1_tick` advances them, and the unselected tick has no effect on the enables.
- R7: On a write, each setting bit i is updated from `cfg_wdata[i]` only when `cfg_wdata[16+i]` is 1, and `cfg_rdata` shows the stored setting from the next cycle.
- R8: A write whose merged setting has plain mode with mid code 2, or power-of-two mode with mid code 3 or a low code above 3, leaves the setting unchanged and sets `cfg_err`. A legal write clears `cfg_err`. `cfg_err` changes only on writes.
- R9: An accepted setting is loaded at the edge where `aclk_en`, `hclk_en` and `pclk_en` are all set together, and it governs ticks from the next cycle on.
- R10: After reset the setting is 0 (divide by 1, all ratios 1:1, power-of-two mode, source 0), `cfg_err` is 0 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src0_tick | input | 1 | Tick qualifier of source 0 |
| src1_tick | input | 1 | Tick qualifier of source 1 |
| cfg_we | input | 1 | Write strobe for the setting |
| cfg_wdata | input | 32 | [31:16] bit mask, [15:0] data |
| cfg_rdata | output | 16 | Stored (staged) setting |
| cfg_err | output | 1 | Last write was refused as illegal |
| aclk_en | output | 1 | Top-level enable pulse |
| hclk_en | output | 1 | Mid-level enable pulse |
| pclk_en | output | 1 | Low-level enable pulse |

## Verification
A behavioural model counts selected ticks since the last common wrap and is compared with the block on every clock. It is driven with a source that ticks every cycle, which exposes off-by-one divisor errors, and with pseudo-random ticks, which show that the dividers advance on ticks and not on clock cycles. Patterns that tick only the unselected source, or both sources at once, separate correct source selection from a design that ORs the two inputs. Setting writes placed in the middle of a period, partially masked writes and illegal codes confirm that staging loads only at the common wrap, that the mask applies per bit, and that refused writes leave the setting untouched.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int ADIV_W   = 5;
  localparam int APRE_W   = 3;
  localparam int HCODE_W  = 2;
  localparam int PCODE_W  = 3;
  localparam int CFG_W    = 16;
  localparam int WORD_W   = 2 * CFG_W;
  localparam int HCNT_W   = 2;   // mid ratio up to 4
  localparam int PCNT_W   = 3;   // low ratio up to 8

  typedef struct packed {
    logic                spare;
    logic                src_sel;
    logic                plain;
    logic [PCODE_W-1:0]  pcode;
    logic [HCODE_W-1:0]  hcode;
    logic [APRE_W-1:0]   apre;
    logic [ADIV_W-1:0]   adiv;
  } cfg_t;

  function automatic logic cfg_illegal(cfg_t c);
    if (c.plain) return (c.hcode == HCODE_W'(2));
    return (c.hcode == HCODE_W'(3)) || (c.pcode > PCODE_W'(3));
  endfunction

  function automatic logic [APRE_W-1:0] pre_limit(cfg_t c);
    return c.plain ? c.apre : '0;
  endfunction

  function automatic logic [HCNT_W-1:0] h_limit(cfg_t c);
    if (c.plain) return HCNT_W'(c.hcode);
    return (HCNT_W'(1) << c.hcode) - HCNT_W'(1);
  endfunction

  function automatic logic [PCNT_W-1:0] p_limit(cfg_t c);
    if (c.plain) return PCNT_W'(c.pcode);
    return (PCNT_W'(1) << c.pcode[1:0]) - PCNT_W'(1);
  endfunction
endpackage

// File: rtl/bcr_cfg_reg.sv
module bcr_cfg_reg
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output cfg_t              staged,
  output logic              err
);
  logic [CFG_W-1:0] mask;
  logic [CFG_W-1:0] data;
  cfg_t             merged;

  assign mask   = wdata[WORD_W-1:CFG_W];
  assign data   = wdata[CFG_W-1:0];
  assign merged = cfg_t'((CFG_W'(staged) & ~mask) | (data & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
      err    <= 1'b0;
    end else if (we) begin
      if (cfg_illegal(merged)) begin
        err <= 1'b1;
      end else begin
        staged <= merged;
        err    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcr_stage_cnt.sv
module bcr_stage_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bus_ratio_gen.sv
module bus_ratio_gen
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src0_tick,
  input  logic              src1_tick,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              cfg_err,
  output logic              aclk_en,
  output logic              hclk_en,
  output logic              pclk_en
);
  cfg_t staged;
  cfg_t active;
  logic tick;
  logic pre_wrap, a_pulse, h_wrap, p_wrap, common;

  bcr_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .staged (staged),
    .err    (cfg_err)
  );

  assign cfg_rdata = CFG_W'(staged);
  assign tick      = active.src_sel ? src1_tick : src0_tick;

  bcr_stage_cnt #(.W(APRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .step(tick), .lim(pre_limit(active)), .wrap(pre_wrap)
  );
  bcr_stage_cnt #(.W(ADIV_W)) u_top (
    .clk(clk), .rst_n(rst_n), .step(pre_wrap), .lim(active.adiv), .wrap(a_pulse)
  );
  bcr_stage_cnt #(.W(HCNT_W)) u_mid (
    .clk(clk), .rst_n(rst_n), .step(a_pulse), .lim(h_limit(active)), .wrap(h_wrap)
  );
  bcr_stage_cnt #(.W(PCNT_W)) u_low (
    .clk(clk), .rst_n(rst_n), .step(a_pulse), .lim(p_limit(active)), .wrap(p_wrap)
  );

  assign common = h_wrap && p_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= '0;
      aclk_en <= 1'b0;
      hclk_en <= 1'b0;
      pclk_en <= 1'b0;
    end else begin
      if (common) active <= staged;
      aclk_en <= a_pulse;
      hclk_en <= h_wrap;
      pclk_en <= p_wrap;
    end
  end
endmodule

// File: rtl/bus_ratio_gen_chk.sv
module bus_ratio_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src0_tick,
  input logic        src1_tick,
  input logic        cfg_we,
  input logic [15:0] cfg_rdata,
  input logic        cfg_err,
  input logic        aclk_en,
  input logic        hclk_en,
  input logic        pclk_en
);
  AST_HCLK_WITHIN_ACLK: assert property (@(posedge clk) disable iff (!rst_n)
    hclk_en |-> aclk_en); // R5
  AST_PCLK_WITHIN_ACLK: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |-> aclk_en); // R5
  AST_ACLK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_en |-> $past(src0_tick || src1_tick)); // R6
  AST_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(cfg_rdata)); // R7
  AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && cfg_err) |-> $stable(cfg_rdata)); // R8
  AST_ERR_ON_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(cfg_err)); // R8
endmodule

bind bus_ratio_gen bus_ratio_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src0_tick(src0_tick), .src1_tick(src1_tick),
  .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
  .aclk_en(aclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en)
);

// File: tb/bus_ratio_gen_bench.sv
module bus_ratio_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src0_tick = 1'b0, src1_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        cfg_err, aclk_en, hclk_en, pclk_en;

  int    total = 0, bad = 0;
  string tag = "R10";
  int    tick_mode = 0;   // 0 src0 always, 1 src0 random, 2 src1 always, 3 both random
  logic [15:0] lfsr = 16'hACE1;
  bit    checking = 1'b0;

  // reference model state
  logic [15:0] m_stg, m_act;
  logic        m_err, ea, eh, ep;
  int          t;

  always #5 clk = ~clk;

  bus_ratio_gen u_bus_ratio_gen (
    .clk(clk), .rst_n(rst_n), .src0_tick(src0_tick), .src1_tick(src1_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .aclk_en(aclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en)
  );

  function automatic bit illegal(logic [15:0] v);
    if (v[13]) return v[9:8] == 2'd2;
    return (v[9:8] == 2'd3) || (v[12:10] > 3'd3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stg = '0; m_act = '0; m_err = 0; t = 0; ea = 0; eh = 0; ep = 0;
    end else begin
      int d, h, p;
      bit tk, a, hh, pp;
      logic [15:0] nv;
      d  = (int'(m_act[4:0]) + 1) * (m_act[13] ? int'(m_act[7:5]) + 1 : 1);
      h  = m_act[13] ? int'(m_act[9:8]) + 1 : (1 << m_act[9:8]);
      p  = m_act[13] ? int'(m_act[12:10]) + 1 : (1 << m_act[12:10]);
      tk = m_act[14] ? src1_tick : src0_tick;
      a = 0; hh = 0; pp = 0;
      if (tk) begin
        t  = t + 1;
        a  = (t % d) == 0;
        hh = a && ((t % (d * h)) == 0);
        pp = a && ((t % (d * p)) == 0);
        if (hh && pp) begin t = 0; m_act = m_stg; end
      end
      if (cfg_we) begin
        nv = (m_stg & ~cfg_wdata[31:16]) | (cfg_wdata[15:0] & cfg_wdata[31:16]);
        if (illegal(nv)) m_err = 1;
        else begin m_stg = nv; m_err = 0; end
      end
      ea = a; eh = hh; ep = pp;
    end
  end

  task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("aclk_en", 16'(aclk_en), 16'(ea));
      chk("hclk_en", 16'(hclk_en), 16'(eh));
      chk("pclk_en", 16'(pclk_en), 16'(ep));
      chk("cfg_rdata", cfg_rdata, m_stg);
      chk("cfg_err", 16'(cfg_err), 16'(m_err));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: begin src0_tick = 1; src1_tick = 0; end
      1: begin src0_tick = lfsr[0]; src1_tick = 0; end
      2: begin src0_tick = 0; src1_tick = 1; end
      default: begin src0_tick = lfsr[0]; src1_tick = lfsr[3]; end
    endcase
  end

  task automatic wr(logic [15:0] mask, logic [15:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = {mask, data};
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R10";  // reset state
    chk("aclk_en", 16'(aclk_en), 16'h0);
    chk("hclk_en", 16'(hclk_en), 16'h0);
    chk("pclk_en", 16'(pclk_en), 16'h0);
    chk("cfg_rdata", cfg_rdata, 16'h0);
    chk("cfg_err", 16'(cfg_err), 16'h0);
    rst_n = 1; checking = 1;
    run(20);
    tag = "R1 R3 R5";                 // adiv=2 mid code 1 low code 2, apre set but unused
    wr(16'hFFFF, 16'h0962);
    run(200);
    tag = "R1"; tick_mode = 1;
    run(300);
    tag = "R7"; tick_mode = 0;        // only the low-code bits are unmasked
    wr(16'h1C00, 16'hE7FF);
    run(100);
    tag = "R2 R4";                    // plain, adiv=1 apre=2 mid 3 low 4
    wr(16'hFFFF, 16'h3341);
    run(400);
    tag = "R8";
    wr(16'hFFFF, 16'h2200);           // plain with mid code 2
    run(5);
    wr(16'h2000, 16'h0000);           // to power-of-two with mid 3 / low 4
    run(5);
    wr(16'hFFFF, 16'h0000);           // legal, clears flag
    run(150);
    tag = "R6";
    wr(16'hFFFF, 16'h4001);           // source 1, divide by 2
    run(50);
    tick_mode = 2; run(50);
    tick_mode = 3; run(200);
    tag = "R9"; tick_mode = 0;
    wr(16'hFFFF, 16'h0C01);           // back to source 0, low ratio 8
    run(37);
    wr(16'hFFFF, 16'h0503);           // change mid-period
    run(150);
    tick_mode = 3;
    wr(16'hFFFF, 16'h2B22);
    run(400);
    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired, got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule